// File: doc/BRIEF.md
# Dual-Channel Prescaled Pulse-Width Modulator

This block drives two independent pulse-width modulated outputs from a single reference clock. Each channel divides the reference clock by a value chosen from a fixed table, then counts the resulting ticks through a programmable period. The output sits at the active level for the first part of the period and at the inactive level for the rest. Software sets the polarity, the divider code, the enable and clock-gate bits, and the mode. In continuous mode the period repeats. In single-pulse mode the channel runs exactly one period each time software writes a one to the start bit.

Software reaches the block through a word-addressed register bus. Writes take one cycle, and read data is a combinational function of the address. One control word holds the fields for both channels. Each channel also has a period word, which holds its active count and its total count. While a channel runs, a new period word is copied in only at the end of a period, so a change never cuts a period short.

Top module: `pwm_dual_gen`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero. Both outputs are high, which is the inactive level for polarity 0.
- R2: Address 0 is the control word. Channel c uses bits [15c+8:15c], laid out from low to high as: divider code in 4 bits, enable, polarity, clock gate, mode, start. All other bits read as zero. Address 1 is the period word of channel 0 and address 2 is the period word of channel 1; each holds the active count in [15:0] and the total count in [31:16]. Address 3 reads zero.
- R3: Divider codes 0–4 produce one counting tick every 120, 180, 240, 360 or 480 clocks, and codes 8–12 produce one every 12000, 24000, 36000, 48000 or 72000 clocks. The divider restarts from zero whenever the channel starts.
- R4: Divider codes 5, 6, 7 and 13–15 are invalid. With an invalid code the channel stops and holds its output at the inactive level.
- R5: A channel runs only when both its enable bit and its clock-gate bit are 1. Otherwise the channel is reset to the start of a period and its output is inactive.
- R6: Polarity 1 makes the active level high, and polarity 0 makes it low. The inactive level is always the inverse of the active level.
- R7: With total count N ≥ 1, a period lasts N ticks, with tick positions 0 to N−1. The output is active at positions below the active count A and inactive at the rest.
- R8: If A ≥ N, the output is active for the whole period. This includes N = 0, which behaves as a one-tick period.
- R9: While a channel runs, a period-word write takes effect only at the next period boundary. While a channel is stopped, the channel picks up the period word at once.
- R10: In mode 1, writing start = 1 runs exactly one period. The hardware then clears the start bit and the output returns to inactive. If a control write lands in the same cycle as that clear, the written value wins.
- R11: In mode 1 with start = 0, the channel is idle and its output is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 2 | Word address, used for both reads and writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the word at bus_addr_i |
| pwm_o | output | 2 | Modulated outputs, bit c for channel c |

## Verification
A behavioural model in the bench tracks the divider phase, period position and latched counts of each channel and is compared with both outputs on every clock. The stimulus aims at the following corner cases:
- A period-word write in the middle of a period. A design that copied the word in at once would show a short or long period.
- A = N, A > N and N = 0. A design that got the saturation rule wrong would drop to inactive for one tick.
- The one-shot path. A design that failed to self-clear the start bit would repeat the pulse, and one that cleared it early would cut the pulse.
- Every valid divider code, including the longest. A design with a wrong divider would move the edges.
- The invalid codes, and each of the enable and gate bits cleared alone. A design that ignored them would keep toggling.

// File: rtl/pwmx_pkg.sv
// pwmx_pkg: shared constants, the per-channel control record and the
// divider decode used by the dual PWM block.
// Assumes at most two channels, so that both 15-bit fields fit in a 32-bit word.
package pwmx_pkg;

    localparam int NCH     = 2;   // channel count
    localparam int CODE_W  = 4;   // divider code width
    localparam int FIELD_W = 15;  // control-word slice per channel
    localparam int DIV_W   = 17;  // wide enough for the largest divider

    // Control fields of one channel, laid out LSB first as code, en, pol, gate, mode, start
    typedef struct packed {
        logic              start;
        logic              mode;
        logic              gate;
        logic              pol;
        logic              en;
        logic [CODE_W-1:0] code;
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);

    // Decode a divider code into a clock count; zero marks an invalid code
    function automatic logic [DIV_W-1:0] div_of(input logic [CODE_W-1:0] c);
        case (c)
            4'h0:    return DIV_W'(120);
            4'h1:    return DIV_W'(180);
            4'h2:    return DIV_W'(240);
            4'h3:    return DIV_W'(360);
            4'h4:    return DIV_W'(480);
            4'h8:    return DIV_W'(12000);
            4'h9:    return DIV_W'(24000);
            4'hA:    return DIV_W'(36000);
            4'hB:    return DIV_W'(48000);
            4'hC:    return DIV_W'(72000);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/pwmx_regs.sv
// pwmx_regs: register file holding the shared control word and one period
// word per channel.
// Assumes single-cycle writes. Read data is combinational on the address.
// A done pulse from a channel clears that channel's start bit; a control
// write in the same cycle overrides the clear.
module pwmx_regs
    import pwmx_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             we_i,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [BUS_W-1:0]                 wdata_i,
    output logic [BUS_W-1:0]                 rdata_o,
    input  logic [NCH-1:0]                   done_i,
    output chan_cfg_t [NCH-1:0]              cfg_o,
    output logic [NCH-1:0][CNT_W-1:0]        act_o,
    output logic [NCH-1:0][CNT_W-1:0]        ent_o
);

    localparam int PER_W = 2 * CNT_W;

    chan_cfg_t [NCH-1:0]        cfg_q;
    logic [NCH-1:0][PER_W-1:0]  per_q;

    // Register update: hardware start clear first, bus write last so it wins
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= '0;
            per_q <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (done_i[i]) cfg_q[i].start <= 1'b0;
            end
            if (we_i && addr_i == '0) begin
                for (int i = 0; i < NCH; i++) begin
                    cfg_q[i] <= chan_cfg_t'(wdata_i[i*FIELD_W +: CFG_W]);
                end
            end
            for (int i = 0; i < NCH; i++) begin
                if (we_i && addr_i == ADDR_W'(i + 1)) per_q[i] <= wdata_i[PER_W-1:0];
            end
        end
    end

    // Read mux: control word at 0, period words after it, zero elsewhere
    always_comb begin
        rdata_o = '0;
        if (addr_i == '0) begin
            for (int i = 0; i < NCH; i++) rdata_o[i*FIELD_W +: CFG_W] = cfg_q[i];
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (addr_i == ADDR_W'(i + 1)) rdata_o[PER_W-1:0] = per_q[i];
            end
        end
    end

    // Field split of the period words
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            act_o[i] = per_q[i][CNT_W-1:0];
            ent_o[i] = per_q[i][PER_W-1:CNT_W];
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/pwmx_prescaler.sv
// pwmx_prescaler: turns the reference clock into a one-clock tick every
// div_of(code) clocks while run_i is high.
// Assumes run_i is low whenever the code is invalid; valid_o reports that.
// The count is held at zero while stopped, so a fresh start is aligned.
module pwmx_prescaler
    import pwmx_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] code_i,
    input  logic              run_i,
    output logic              valid_o,
    output logic              tick_o
);

    logic [DIV_W-1:0] div;
    logic [DIV_W-1:0] pre_q;

    assign div     = div_of(code_i);
    assign valid_o = (div != '0);
    assign tick_o  = run_i && (pre_q >= div - DIV_W'(1));

    // Divider count: clear while stopped or at wrap, else advance
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i) pre_q <= '0;
        else if (tick_o)       pre_q <= '0;
        else                   pre_q <= pre_q + DIV_W'(1);
    end

    AST_PRE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run_i) |-> (pre_q == '0)) else $error("divider not aligned on start"); // R3

endmodule

// File: rtl/pwmx_channel.sv
// pwmx_channel: the period counter and output shaping for one channel.
// Assumes tick_i comes from a prescaler gated by go_o. The period values
// are copied in while stopped and at each period wrap. In mode 1 the
// channel flags done_o at the wrap so that the start bit is cleared.
module pwmx_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             gate_i,
    input  logic             pol_i,
    input  logic             mode_i,
    input  logic             start_i,
    input  logic             code_ok_i,
    input  logic [CNT_W-1:0] act_i,
    input  logic [CNT_W-1:0] ent_i,
    input  logic             tick_i,
    output logic             go_o,
    output logic             done_o,
    output logic             pwm_o
);

    logic [CNT_W-1:0] cnt_q, act_l, ent_l;
    logic             last, hit;

    assign go_o   = en_i && gate_i && code_ok_i && (!mode_i || start_i);
    assign last   = (ent_l == '0) || (cnt_q >= ent_l - CNT_W'(1));
    assign done_o = go_o && tick_i && last && mode_i;
    assign hit    = (cnt_q < act_l) || (act_l >= ent_l);
    assign pwm_o  = (go_o && hit) ? pol_i : !pol_i;

    // Period position and latched counts: follow the registers while stopped
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            act_l <= '0;
            ent_l <= '0;
        end else if (!go_o) begin
            cnt_q <= '0;
            act_l <= act_i;
            ent_l <= ent_i;
        end else if (tick_i) begin
            if (last) begin
                cnt_q <= '0;
                act_l <= act_i;
                ent_l <= ent_i;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (go_o && !tick_i) |=> ($stable(act_l) && $stable(ent_l))) else $error("period copy moved mid-period"); // R9
    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (go_o && ent_l != '0) |-> (cnt_q < ent_l)) else $error("position beyond period"); // R7

endmodule

// File: rtl/pwm_dual_gen.sv
// pwm_dual_gen: top of the two-channel prescaled PWM. It ties the register
// file to one prescaler and one period counter per channel.
// Assumes a single clock domain and a synchronous active-low reset.
module pwm_dual_gen
    import pwmx_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic [NCH-1:0]    pwm_o
);

    chan_cfg_t [NCH-1:0]         cfg;
    logic [NCH-1:0][CNT_W-1:0]   act, ent;
    logic [NCH-1:0]              done, go, tick, valid;

    pwmx_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (bus_we_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .rdata_o (bus_rdata_o),
        .done_i  (done),
        .cfg_o   (cfg),
        .act_o   (act),
        .ent_o   (ent)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwmx_prescaler u_pre (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .code_i  (cfg[g].code),
            .run_i   (go[g]),
            .valid_o (valid[g]),
            .tick_o  (tick[g])
        );

        pwmx_channel #(.CNT_W(CNT_W)) u_chan (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .en_i      (cfg[g].en),
            .gate_i    (cfg[g].gate),
            .pol_i     (cfg[g].pol),
            .mode_i    (cfg[g].mode),
            .start_i   (cfg[g].start),
            .code_ok_i (valid[g]),
            .act_i     (act[g]),
            .ent_i     (ent[g]),
            .tick_i    (tick[g]),
            .go_o      (go[g]),
            .done_o    (done[g]),
            .pwm_o     (pwm_o[g])
        );

        AST_OFF_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(cfg[g].en && cfg[g].gate) |-> (pwm_o[g] == !cfg[g].pol)) else $error("stopped channel active"); // R5
        AST_BAD_CODE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !valid[g] |-> (pwm_o[g] == !cfg[g].pol)) else $error("invalid code not idle"); // R4
        AST_SHOT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (done[g] && !(bus_we_i && bus_addr_i == '0)) |=> !cfg[g].start) else $error("start bit kept"); // R10
    end

endmodule

// File: tb/sim_pwm_dual_gen.sv
// sim_pwm_dual_gen: bench with a behavioural per-clock model of both channels.
module sim_pwm_dual_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  pwm;

    int compared = 0;
    int mismatched = 0;
    string phase = "R1";
    bit started = 0;
    bit finished = 0;
    int cyc = 0;

    always #4 clk = ~clk; // 125 MHz

    pwm_dual_gen u0 (
        .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pwm)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_ctrl = '0;
    logic [31:0] m_per [2] = '{32'd0, 32'd0};
    int m_pre [2] = '{0, 0};
    int m_cnt [2] = '{0, 0};
    int m_la  [2] = '{0, 0};
    int m_le  [2] = '{0, 0};
    logic [31:0] m_next;

    function automatic int divx(input int c);
        case (c)
            0: return 120;    1: return 180;    2: return 240;
            3: return 360;    4: return 480;    8: return 12000;
            9: return 24000;  10: return 36000; 11: return 48000;
            12: return 72000;
            default: return 0;
        endcase
    endfunction

    function automatic logic [8:0] fld(input int ch);
        return m_ctrl[ch*15 +: 9];
    endfunction

    function automatic bit m_go(input int ch);
        logic [8:0] f = fld(ch);
        return f[4] && f[6] && (divx(int'(f[3:0])) != 0) && (!f[7] || f[8]);
    endfunction

    function automatic logic m_exp(input int ch);
        logic [8:0] f = fld(ch);
        if (m_go(ch) && ((m_cnt[ch] < m_la[ch]) || (m_la[ch] >= m_le[ch]))) return f[5];
        return !f[5];
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_ctrl = '0;
            for (int i = 0; i < 2; i++) begin
                m_per[i] = '0; m_pre[i] = 0; m_cnt[i] = 0; m_la[i] = 0; m_le[i] = 0;
            end
        end else begin
            m_next = m_ctrl;
            for (int i = 0; i < 2; i++) begin
                if (!m_go(i)) begin
                    m_pre[i] = 0; m_cnt[i] = 0;
                    m_la[i] = int'(m_per[i][15:0]); m_le[i] = int'(m_per[i][31:16]);
                end else if (m_pre[i] >= divx(int'(fld(i)[3:0])) - 1) begin
                    m_pre[i] = 0;
                    if (m_le[i] == 0 || m_cnt[i] >= m_le[i] - 1) begin
                        m_cnt[i] = 0;
                        m_la[i] = int'(m_per[i][15:0]); m_le[i] = int'(m_per[i][31:16]);
                        if (fld(i)[7]) m_next[i*15 + 8] = 1'b0;
                    end else begin
                        m_cnt[i] = m_cnt[i] + 1;
                    end
                end else begin
                    m_pre[i] = m_pre[i] + 1;
                end
            end
            if (we) begin
                if (addr == 2'd0) m_next = wdata & 32'h00FF_81FF;
                if (addr == 2'd1) m_per[0] = wdata;
                if (addr == 2'd2) m_per[1] = wdata;
            end
            m_ctrl = m_next;
        end
    end

    // Per-clock output comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            for (int i = 0; i < 2; i++) begin
                compared++;
                if (pwm[i] !== m_exp(i)) begin
                    mismatched++;
                    $display("FAIL %s pwm[%0d] got %b expected %b at cycle %0d", phase, i, pwm[i], m_exp(i), cyc);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000 && !finished) begin
            finished = 1;
            mismatched++;
            compared++;
            $display("FAIL watchdog expired got cycle %0d expected below 195000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] cw(input int ch, input int code, input bit en, input bit pol,
                                       input bit gate, input bit mode, input bit start);
        logic [8:0] f = {start, mode, gate, pol, en, code[3:0]};
        return 32'(f) << (15 * ch);
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1;
        compared++;
        if (rdata !== exp) begin
            mismatched++;
            $display("FAIL %s read addr %0d got %h expected %h", req, a, rdata, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        phase = "R1";
        idle(3);
        rst_n = 1'b1;
        rd_chk(2'd0, 32'h0, "R1");
        rd_chk(2'd1, 32'h0, "R1");
        rd_chk(2'd2, 32'h0, "R1");
        idle(4);

        // R2: register map and read-back masking
        phase = "R2";
        wr(2'd1, 32'hDEAD_BEEF);
        rd_chk(2'd1, 32'hDEAD_BEEF, "R2");
        wr(2'd2, 32'h1234_5678);
        rd_chk(2'd2, 32'h1234_5678, "R2");
        wr(2'd0, 32'hFFFF_FFFF);
        rd_chk(2'd0, 32'h00FF_81FF, "R2");
        rd_chk(2'd3, 32'h0, "R2");
        wr(2'd0, 32'h0);
        rd_chk(2'd0, 32'h0, "R2");

        // R7: duty and period on both channels, both polarities (R6)
        phase = "R7";
        wr(2'd1, {16'd5, 16'd2});
        wr(2'd2, {16'd3, 16'd1});
        wr(2'd0, cw(0, 0, 1, 1, 1, 0, 0) | cw(1, 1, 1, 0, 1, 0, 0));
        idle(1500);

        // R9: period change mid-period lands only at the boundary
        phase = "R9";
        idle(37);
        wr(2'd1, {16'd4, 16'd3});
        idle(200);
        wr(2'd2, {16'd2, 16'd1});
        idle(1500);

        // R8: active count at or above the total, and a zero total
        phase = "R8";
        wr(2'd1, {16'd4, 16'd7});
        wr(2'd2, 32'h0);
        idle(1000);
        wr(2'd1, {16'd3, 16'd3});
        idle(800);

        // R6: polarity change while running
        phase = "R6";
        wr(2'd1, {16'd4, 16'd1});
        wr(2'd0, cw(0, 0, 1, 0, 1, 0, 0) | cw(1, 1, 1, 1, 1, 0, 0));
        idle(700);

        // R4: invalid divider codes
        phase = "R4";
        wr(2'd0, cw(0, 6, 1, 1, 1, 0, 0) | cw(1, 13, 1, 0, 1, 0, 0));
        idle(300);
        wr(2'd0, cw(0, 5, 1, 0, 1, 0, 0) | cw(1, 7, 1, 1, 1, 0, 0));
        idle(300);
        wr(2'd0, cw(0, 15, 1, 1, 1, 0, 0) | cw(1, 14, 1, 1, 1, 0, 0));
        idle(300);

        // R5: enable or gate cleared alone
        phase = "R5";
        wr(2'd0, cw(0, 0, 0, 1, 1, 0, 0) | cw(1, 0, 1, 1, 0, 0, 0));
        idle(400);

        // R3: every short divider code in turn
        phase = "R3";
        wr(2'd1, {16'd2, 16'd1});
        for (int c = 0; c < 5; c++) begin
            wr(2'd0, cw(0, c, 1, 1, 1, 0, 0));
            idle(2 * divx(c) + 60);
        end

        // R11: single-pulse mode with no start is idle
        phase = "R11";
        wr(2'd0, cw(0, 0, 1, 1, 1, 1, 0));
        idle(500);

        // R10: one pulse, start bit self-clears, relaunch works
        phase = "R10";
        wr(2'd1, {16'd2, 16'd1});
        wr(2'd0, cw(0, 0, 1, 1, 1, 1, 1));
        idle(120);
        rd_chk(2'd0, cw(0, 0, 1, 1, 1, 1, 1), "R10");
        idle(200);
        rd_chk(2'd0, cw(0, 0, 1, 1, 1, 1, 0), "R10");
        idle(300);
        wr(2'd0, cw(0, 0, 1, 0, 1, 1, 1));
        idle(400);
        rd_chk(2'd0, cw(0, 0, 1, 0, 1, 1, 0), "R10");

        // R3: long divider codes on both channels at once
        phase = "R3";
        wr(2'd1, {16'd2, 16'd1});
        wr(2'd2, {16'd2, 16'd1});
        wr(2'd0, cw(0, 8, 1, 1, 1, 0, 0) | cw(1, 12, 1, 1, 1, 0, 0));
        idle(72300);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule